// File: doc/BRIEF.md
# Character LCD Host Bus Port

This block is the processor-facing side of a character LCD controller. A host drives a register-select line, a read/write line, an asynchronous enable strobe and an eight-line bidirectional data bus. The port brings the strobe into the internal clock domain and acts on each falling edge of the strobe. On writes it builds instruction or data bytes and hands each completed byte to a command executor as a one-cycle valid pulse. A type bit marks the byte as an instruction or as RAM data. On reads it returns one of two words. A status read gives the executor's busy flag and address counter. A data read gives a prefetched RAM byte.

The bus runs either at full width or in nibble mode, where only the upper four lines carry data and each byte takes two strobes. The port watches the instruction bytes it forwards. When it sees a width-select instruction it switches its own width. The executor refills the prefetch register through a load strobe. The port signals each finished data read so that the executor can advance its address and fetch the next location. The bus is modelled as separate input, output and output-enable signals.

Top module: `chlcd_host_port`

## Requirements
- R1: With select low and read/write low, a falling strobe in byte mode produces exactly one `cmdValid` pulse, with `cmdIsData`=0 and `cmdByte` equal to the bus value held during the strobe.
- R2: With select high and read/write low, the transfer is forwarded the same way as R1 but with `cmdIsData`=1.
- R3: With select low and read/write high in byte mode, `busOut` shows `execBusy` on bit 7 and `execAddr` on bits 6..0 while the strobe is high.
- R4: With select high and read/write high, `busOut` shows the byte most recently loaded through `fillValid`/`fillData`. Each completed data read gives exactly one `rdTaken` pulse.
- R5: `busOe` is high only while the synchronised strobe is high and read/write is high. It is low during writes and while the strobe is low.
- R6: After reset the port is in byte mode with the nibble phase at upper, and `busOe`, `cmdValid` and `rdTaken` are low.
- R7: A forwarded instruction byte whose bits 7..5 are 001 sets the width from bit 4: 1 selects byte mode and 0 selects nibble mode. The nibble phase returns to upper whenever the width changes.
- R8: In nibble mode a write uses bus bits 7..4 only and takes two strobes, upper half first. No byte is forwarded after the first strobe. The byte is forwarded after the second, and bits 3..0 of the bus are ignored.
- R9: In nibble mode a read presents the upper half of the selected word on bits 7..4 during the first strobe and the lower half during the second, with bits 3..0 driven 0. A nibble-mode data read pulses `rdTaken` only after its second strobe.
- R10: Reads never produce `cmdValid`. Writes and status reads never produce `rdTaken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Asynchronous host enable strobe |
| selData | input | 1 | 0 selects instruction/status, 1 selects RAM data |
| readNotWrite | input | 1 | 1 for read, 0 for write |
| busIn | input | 8 | Data lines as driven by the host |
| busOut | output | 8 | Data lines driven by the port |
| busOe | output | 1 | Output enable for busOut |
| cmdValid | output | 1 | One-cycle pulse: a completed byte is ready |
| cmdIsData | output | 1 | Type of the forwarded byte: 1 data, 0 instruction |
| cmdByte | output | 8 | Forwarded byte |
| rdTaken | output | 1 | One-cycle pulse: a data read finished |
| execBusy | input | 1 | Busy flag from the executor |
| execAddr | input | 7 | Address counter from the executor |
| fillValid | input | 1 | Load strobe for the prefetch register |
| fillData | input | 8 | Next RAM byte for the prefetch register |

## Verification
The bench targets the nibble-phase handling. A port that forwarded after the first half would emit a stray byte, and the scoreboard flags that. A port that swapped the halves would assemble 0x14 where 0x41 is expected. Width switching is tested in both directions, using a width-select instruction that arrives as two nibbles. A port that failed to switch, or that left a stale phase behind, would misassemble every following byte. The bench also compares read words half by half in nibble mode, and it counts `rdTaken` pulses against completed data reads. A port that advanced the prefetch on status reads, or after the first half, would show the wrong count.

// File: rtl/chlcd_port_pkg.sv
package chlcd_port_pkg;
  typedef struct packed {
    logic captureHigh;
    logic captureByte;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    KIND_INSTR_WR  = 2'b00,
    KIND_STATUS_RD = 2'b01,
    KIND_DATA_WR   = 2'b10,
    KIND_DATA_RD   = 2'b11
  } busKind_t;
endpackage

// File: rtl/chlcd_port_ctrl.sv
module chlcd_port_ctrl
  import chlcd_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobe,
  input  logic              selData,
  input  logic              readNotWrite,
  input  logic [DATA_W-1:0] asmByte,
  output logic              wide,
  output logic              phase,
  output dpStrobe_t         stb,
  output logic              cmdValid,
  output logic              cmdIsData,
  output logic              rdTaken,
  output logic              busOe
);
  localparam int FS_TOP = DATA_W - 1;

  logic [SYNC_STAGES:0] syncQ;
  logic sNow, sPrev, fall, complete;
  busKind_t kind;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], strobe};
  end

  assign sNow     = syncQ[SYNC_STAGES-1];
  assign sPrev    = syncQ[SYNC_STAGES];
  assign fall     = sPrev & ~sNow;
  assign kind     = busKind_t'({selData, readNotWrite});
  assign complete = fall & (wide | phase);
  assign busOe    = sNow & readNotWrite;

  always_comb begin
    stb = '0;
    stb.captureHigh = fall & ~wide & ~phase & ~readNotWrite;
    stb.captureByte = complete & ~readNotWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wide      <= 1'b1;
      phase     <= 1'b0;
      cmdValid  <= 1'b0;
      cmdIsData <= 1'b0;
      rdTaken   <= 1'b0;
    end else begin
      cmdValid <= 1'b0;
      rdTaken  <= 1'b0;
      if (fall && !wide) phase <= ~phase;
      if (complete && !readNotWrite) begin
        cmdValid  <= 1'b1;
        cmdIsData <= selData;
      end
      if (complete && kind == KIND_DATA_RD) rdTaken <= 1'b1;
      if (complete && kind == KIND_INSTR_WR &&
          asmByte[FS_TOP -: 3] == 3'b001 && asmByte[FS_TOP-3] != wide) begin
        wide  <= asmByte[FS_TOP-3];
        phase <= 1'b0;
      end
    end
  end

  // R7: a width change leaves the phase at upper
  assert_phase_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wide != $past(wide)) |-> !phase);
  // R1: strobe synchronisation keeps forwarded bytes apart
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  // R10: a transfer is either forwarded or counted as a read, never both
  assert_rd_wr_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && rdTaken));
  // R5: enable never drives during a write
  assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> readNotWrite);
endmodule

// File: rtl/chlcd_port_dp.sv
module chlcd_port_dp
  import chlcd_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  input  logic              selData,
  input  logic              wide,
  input  logic              phase,
  input  dpStrobe_t         stb,
  input  logic              execBusy,
  input  logic [DATA_W-2:0] execAddr,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData,
  output logic [DATA_W-1:0] asmByte,
  output logic [DATA_W-1:0] cmdByte,
  output logic [DATA_W-1:0] busOut
);
  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0]  hiNib;
  logic [DATA_W-1:0] prefetch, word;

  assign asmByte = wide ? busIn : {hiNib, busIn[DATA_W-1 -: NIB_W]};
  assign word    = selData ? prefetch : {execBusy, execAddr};

  always_comb begin
    if (wide)       busOut = word;
    else if (phase) busOut = {word[NIB_W-1:0], {NIB_W{1'b0}}};
    else            busOut = {word[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNib    <= '0;
      cmdByte  <= '0;
      prefetch <= '0;
    end else begin
      if (stb.captureHigh) hiNib   <= busIn[DATA_W-1 -: NIB_W];
      if (stb.captureByte) cmdByte <= asmByte;
      if (fillValid)       prefetch <= fillData;
    end
  end

  // R4: the prefetch register holds the last loaded byte
  assert_prefetch_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> prefetch == $past(fillData));
endmodule

// File: rtl/chlcd_host_port.sv
module chlcd_host_port
  import chlcd_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobe,
  input  logic              selData,
  input  logic              readNotWrite,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              cmdValid,
  output logic              cmdIsData,
  output logic [DATA_W-1:0] cmdByte,
  output logic              rdTaken,
  input  logic              execBusy,
  input  logic [DATA_W-2:0] execAddr,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData
);
  logic              wide, phase;
  logic [DATA_W-1:0] asmByte;
  dpStrobe_t         stb;

  chlcd_port_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selData(selData),
    .readNotWrite(readNotWrite), .asmByte(asmByte), .wide(wide), .phase(phase),
    .stb(stb), .cmdValid(cmdValid), .cmdIsData(cmdIsData), .rdTaken(rdTaken),
    .busOe(busOe));

  chlcd_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .selData(selData), .wide(wide),
    .phase(phase), .stb(stb), .execBusy(execBusy), .execAddr(execAddr),
    .fillValid(fillValid), .fillData(fillData), .asmByte(asmByte),
    .cmdByte(cmdByte), .busOut(busOut));
endmodule

// File: tb/chlcd_host_port_tb.sv
module chlcd_host_port_tb;
  logic clk = 0, rstN = 0, strobe = 0, selData = 0, readNotWrite = 0;
  logic [7:0] busIn = 0, busOut, cmdByte, fillData = 0;
  logic busOe, cmdValid, cmdIsData, rdTaken, execBusy = 0, fillValid = 0;
  logic [6:0] execAddr = 0;
  int checks = 0, fails = 0, rdCount = 0;
  logic [8:0] expQ[$];
  logic [7:0] rdWord;
  logic rdOe;

  always #2 clk = ~clk;

  chlcd_host_port u_dut (.clk(clk), .rstN(rstN), .strobe(strobe), .selData(selData),
    .readNotWrite(readNotWrite), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .cmdValid(cmdValid), .cmdIsData(cmdIsData), .cmdByte(cmdByte), .rdTaken(rdTaken),
    .execBusy(execBusy), .execAddr(execAddr), .fillValid(fillValid), .fillData(fillData));

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares forwarded bytes against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) check("R8/R10 unexpected byte", {cmdIsData, cmdByte}, 9'h1ff);
      else check("R1/R2 forwarded byte", {cmdIsData, cmdByte}, expQ.pop_front());
    end
    if (rstN && rdTaken) rdCount++;
  end

  task automatic busCycle(input logic rs, input logic rw, input logic [7:0] d);
    @(negedge clk);
    selData = rs; readNotWrite = rw; busIn = d; strobe = 1;
    repeat (6) @(negedge clk);
    rdWord = busOut; rdOe = busOe;
    strobe = 0;
    repeat (6) @(negedge clk);
    check("R5 oe low after strobe", {8'h0, busOe}, 9'h0);
  endtask

  task automatic wr8(input logic rs, input logic [7:0] d);
    expQ.push_back({rs, d});
    busCycle(rs, 1'b0, d);
  endtask

  task automatic wr4(input logic rs, input logic [7:0] d);
    busCycle(rs, 1'b0, {d[7:4], 4'hA});
    check("R8 no byte after first half", {8'h0, expQ.size() != 0}, 9'h0);
    expQ.push_back({rs, d});
    busCycle(rs, 1'b0, {d[3:0], 4'h5});
  endtask

  task automatic fill(input logic [7:0] d);
    @(negedge clk); fillValid = 1; fillData = d;
    @(negedge clk); fillValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset oe", {8'h0, busOe}, 9'h0);
    check("R6 reset valid", {7'h0, cmdValid, rdTaken}, 9'h0);
    rstN = 1;
    // R1, R2: byte-mode writes
    wr8(1'b0, 8'h0F);
    wr8(1'b1, 8'hA5);
    check("R5 oe low during write", {8'h0, rdOe}, 9'h0);
    // R3: status read in byte mode (also confirms R6 byte mode)
    execBusy = 1; execAddr = 7'h2B;
    busCycle(1'b0, 1'b1, 8'h00);
    check("R3 status word", {1'b0, rdWord}, 9'h0AB);
    check("R5 oe high on read", {8'h0, rdOe}, 9'h1);
    check("R10 no rdTaken on status", rdCount, 0);
    // R4: data read from prefetch
    fill(8'h5C);
    busCycle(1'b1, 1'b1, 8'h00);
    check("R4 data word", {1'b0, rdWord}, 9'h05C);
    check("R4 rdTaken once", rdCount, 1);
    // R7: switch to nibble mode
    wr8(1'b0, 8'h28);
    // R8: nibble writes, upper half first
    wr4(1'b1, 8'h41);
    wr4(1'b0, 8'h0C);
    // R9: nibble status read
    execBusy = 0; execAddr = 7'h15;
    busCycle(1'b0, 1'b1, 8'h00);
    check("R9 status upper half", {1'b0, rdWord}, 9'h010);
    busCycle(1'b0, 1'b1, 8'h00);
    check("R9 status lower half", {1'b0, rdWord}, 9'h050);
    // R9: nibble data read
    fill(8'hE7);
    busCycle(1'b1, 1'b1, 8'h00);
    check("R9 data upper half", {1'b0, rdWord}, 9'h0E0);
    check("R9 no rdTaken after first half", rdCount, 1);
    busCycle(1'b1, 1'b1, 8'h00);
    check("R9 data lower half", {1'b0, rdWord}, 9'h070);
    check("R9 rdTaken after second half", rdCount, 2);
    // R7: back to byte mode via a two-half width-select
    wr4(1'b0, 8'h30);
    wr8(1'b1, 8'h99);
    execBusy = 1; execAddr = 7'h7F;
    busCycle(1'b0, 1'b1, 8'h00);
    check("R7 byte mode restored", {1'b0, rdWord}, 9'h0FF);
    check("R10 queue drained", {5'h0, 4'(expQ.size())}, 9'h0);
    check("R10 rd count final", rdCount, 2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule